// File: doc/BRIEF.md
# Four-Error BCH Parity Packer and Correction Applier

This block sits between a 4-bit-correcting BCH engine and a 512-byte sector buffer. On the write side it takes the engine's four 32-bit parity registers and packs the eight 10-bit parity words they hold into a 10-byte code. Each register carries two words, one at bits 9:0 and one at bits 25:16. The packing is a plain little-endian bit stream: word k lands on code bits 10k+9..10k, and code byte j is code bits 8j+7..8j.

On the read side a single `rd_start` pulse latches the 10 stored code bytes. If every byte is 0xFF the sector is taken as erased and the operation ends at once. Otherwise the block splits the code back into words and feeds them to the engine one per clock, last word first. It then checks the engine's syndromes. If any is non-zero it starts the engine's error calculation and follows its 4-bit correction state through a start phase and a finish phase, each with a timeout.

When the engine reports a correctable result, the block reads up to four (address, value) pairs. It mirrors each address into a sector byte index and emits an XOR fix for every index that falls inside the sector. A final `done` pulse carries the outcome flags and the number of fixes emitted.

Top module: `bch4_fix_unit`

## Requirements
- R1: `wr_code` bits 10k+9..10k equal parity word k for k = 0..7, so that code byte 0 is word0[7:0], byte 1 is {word1[5:0], word0[9:8]}, byte 2 is {word2[3:0], word1[9:6]}, byte 3 is {word3[1:0], word2[9:4]}, byte 4 is word3[9:2], and bytes 5..9 repeat this pattern for words 4..7.
- R2: Parity word k is taken from `wr_par` register k/2 (bits 32r+31..32r), at bits 9:0 when k is even and at bits 25:16 when k is odd. All other register bits have no effect on `wr_code`.
- R3: If all 10 latched code bytes are 0xFF, the block produces no `ld_valid` and no `calc_start`. It then gives one `done` with `done_erased`=1 and `done_count`=0.
- R4: Otherwise the block sends eight words on `ld_valid`/`ld_word`, one per clock, in the order word7, word6, ... word0. Here word k is code bits 10k+9..10k.
- R5: Two clocks after the last word, `eng_syn` is sampled. If it is zero, `done` follows with all flags clear and `done_count`=0, and no `calc_start` is issued.
- R6: For a non-zero syndrome, `calc_start` pulses for exactly one clock. The block then waits for the state field `eng_stat[11:8]` to exceed 3, and after that for it to return to 0..3.
- R7: A final state of 0 ends with no fixes and no flags. A final state of 1 ends with `done_uncorr`=1 and no fixes.
- R8: A final state of 2 or 3 gives `eng_stat[17:16]`+1 errors. Error i takes its address from `err_addr` word i/2 and its value from `err_val` word i/2. The address is bits 9:0 and the value bits 7:0 when i is even; when i is odd they are bits 25:16 and 23:16.
- R9: Each error gives index 519 minus its address. A fix (`fix_valid`, `fix_idx`, `fix_mask`) is emitted, one per clock in error order, only when that index is 0..511. `done_count` equals the number of fixes emitted.
- R10: If either wait of R6 lasts `TMO_CYCLES` clocks, the operation ends with `done_timeout`=1 and no fixes.
- R11: Each accepted `rd_start` gives exactly one `done`. `rd_start` has no effect while an operation is in progress, and at most one of `ld_valid`, `calc_start`, `fix_valid` and `done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_par | input | 128 | Four engine parity registers (write side) |
| wr_code | output | 80 | Packed 10-byte parity code |
| rd_start | input | 1 | Start a read-side correction pass |
| rd_code | input | 80 | Stored 10-byte code, byte j at bits 8j+7..8j |
| ld_valid | output | 1 | Parity word load strobe to the engine |
| ld_word | output | 10 | Parity word being loaded |
| eng_syn | input | 40 | Four 10-bit syndromes from the engine |
| calc_start | output | 1 | Start of the engine's error calculation |
| eng_stat | input | 32 | Engine status (state at 11:8, count at 17:16) |
| err_addr | input | 64 | Two error address registers |
| err_val | input | 64 | Two error value registers |
| fix_valid | output | 1 | Buffer fix strobe |
| fix_idx | output | 9 | Sector byte index to fix |
| fix_mask | output | 8 | XOR mask for that byte |
| done | output | 1 | End of pass, one clock |
| done_erased | output | 1 | Pass ended on an erased code |
| done_uncorr | output | 1 | Engine reported too many errors |
| done_timeout | output | 1 | A status wait expired |
| done_count | output | 3 | Number of fixes emitted |

## Verification
On every cycle the assertions check several properties. The load, start, fix and done strobes never overlap, and `calc_start` never lasts two clocks. The load burst never cuts off after one word. An erased finish never reports fixes or a timeout, the wait counter stays under its limit, and the fix count never exceeds four. The bench's scenarios are needed to show that the bits land in the right places: the bit mapping of the packer, the reverse load order, the mirrored indices, the dropping of out-of-range addresses, and the choice of register half. Only those scenarios also show the outcome of each correction state, the timeout, and that a second start during a pass is ignored.

// File: rtl/bch4_fix_pkg.sv
package bch4_fix_pkg;
  localparam int WORD_W   = 10;
  localparam int REG_W    = 32;
  localparam int HALF_OFS = 16;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_CHECK,
    SQ_LOAD,
    SQ_SETTLE,
    SQ_SYN,
    SQ_WAIT_GO,
    SQ_WAIT_END,
    SQ_FIX,
    SQ_DONE
  } seq_state_e;
endpackage

// File: rtl/bch4_code_packer.sv
module bch4_code_packer
  import bch4_fix_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic [NREG*REG_W-1:0]    par_regs,
  output logic [NREG*2*WORD_W-1:0] code
);
  localparam int NWORDS = NREG * 2;

  logic [NREG*REG_W-1:0] unused_par;
  assign unused_par = par_regs;

  // Word k sits in register k/2, lower or upper half.
  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    assign code[k*WORD_W +: WORD_W] =
      par_regs[(k/2)*REG_W + (k%2)*HALF_OFS +: WORD_W];
  end
endmodule

// File: rtl/bch4_code_unpacker.sv
module bch4_code_unpacker
  import bch4_fix_pkg::*;
#(
  parameter int NWORDS = 8
) (
  input  logic [NWORDS*WORD_W-1:0] code,
  output logic [NWORDS*WORD_W-1:0] words,
  output logic                     erased
);
  localparam int CODE_BYTES = NWORDS * WORD_W / 8;
  localparam int GRP_BYTES  = 5;
  localparam int NGRP       = CODE_BYTES / GRP_BYTES;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [7:0] b0, b1, b2, b3, b4;
    assign b0 = code[(g*GRP_BYTES+0)*8 +: 8];
    assign b1 = code[(g*GRP_BYTES+1)*8 +: 8];
    assign b2 = code[(g*GRP_BYTES+2)*8 +: 8];
    assign b3 = code[(g*GRP_BYTES+3)*8 +: 8];
    assign b4 = code[(g*GRP_BYTES+4)*8 +: 8];
    assign words[(g*4+0)*WORD_W +: WORD_W] = {b1[1:0], b0};
    assign words[(g*4+1)*WORD_W +: WORD_W] = {b2[3:0], b1[7:2]};
    assign words[(g*4+2)*WORD_W +: WORD_W] = {b3[5:0], b2[7:4]};
    assign words[(g*4+3)*WORD_W +: WORD_W] = {b4, b3[7:6]};
  end

  assign erased = &code;
endmodule

// File: rtl/bch4_err_mapper.sv
module bch4_err_mapper
  import bch4_fix_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  parameter int IDX_W      = $clog2(SECT_BYTES)
) (
  input  logic [WORD_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  localparam int MIRROR = SECT_BYTES + 7;
  localparam int DIFF_W = WORD_W + 2;

  logic [DIFF_W-1:0] diff;

  assign diff = DIFF_W'(MIRROR) - {2'b00, addr};
  assign hit  = (diff[DIFF_W-1:IDX_W] == '0);
  assign idx  = diff[IDX_W-1:0];
endmodule

// File: rtl/bch4_fix_unit.sv
module bch4_fix_unit
  import bch4_fix_pkg::*;
#(
  parameter int NREG       = 4,
  parameter int SECT_BYTES = 512,
  parameter int TMO_CYCLES = 10240,
  parameter int IDX_W      = $clog2(SECT_BYTES),
  parameter int NWORDS     = NREG * 2,
  parameter int CODE_W     = NWORDS * WORD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREG*REG_W-1:0] wr_par,
  output logic [CODE_W-1:0]     wr_code,
  input  logic                  rd_start,
  input  logic [CODE_W-1:0]     rd_code,
  output logic                  ld_valid,
  output logic [WORD_W-1:0]     ld_word,
  input  logic [4*WORD_W-1:0]   eng_syn,
  output logic                  calc_start,
  input  logic [REG_W-1:0]      eng_stat,
  input  logic [2*REG_W-1:0]    err_addr,
  input  logic [2*REG_W-1:0]    err_val,
  output logic                  fix_valid,
  output logic [IDX_W-1:0]      fix_idx,
  output logic [7:0]            fix_mask,
  output logic                  done,
  output logic                  done_erased,
  output logic                  done_uncorr,
  output logic                  done_timeout,
  output logic [2:0]            done_count
);
  localparam int CNT_W = $clog2(NWORDS);
  localparam int TMO_W = $clog2(TMO_CYCLES + 1);

  seq_state_e         st_q, st_n;
  logic [CODE_W-1:0]  code_q;
  logic               code_en;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [TMO_W-1:0]   tmo_q, tmo_n;
  logic [1:0]         eidx_q, eidx_n, nerr_q, nerr_n;
  logic [2:0]         app_q, app_n;
  logic               er_q, er_n, uc_q, uc_n, to_q, to_n;

  logic [CODE_W-1:0]  words;
  logic               erased;
  logic [3:0]         cstate;
  logic               busy;
  logic [REG_W-1:0]   areg, vreg;
  logic [WORD_W-1:0]  cur_addr;
  logic [IDX_W-1:0]   cur_idx;
  logic               cur_hit;
  logic [REG_W-1:0]   unused_stat;

  assign unused_stat = eng_stat;

  bch4_code_packer #(.NREG(NREG)) u_pack (
    .par_regs (wr_par),
    .code     (wr_code)
  );

  bch4_code_unpacker #(.NWORDS(NWORDS)) u_unpack (
    .code   (code_q),
    .words  (words),
    .erased (erased)
  );

  assign areg     = eidx_q[1] ? err_addr[2*REG_W-1:REG_W] : err_addr[REG_W-1:0];
  assign vreg     = eidx_q[1] ? err_val[2*REG_W-1:REG_W]  : err_val[REG_W-1:0];
  assign cur_addr = eidx_q[0] ? areg[HALF_OFS +: WORD_W] : areg[WORD_W-1:0];

  bch4_err_mapper #(.SECT_BYTES(SECT_BYTES), .IDX_W(IDX_W)) u_map (
    .addr (cur_addr),
    .idx  (cur_idx),
    .hit  (cur_hit)
  );

  assign cstate = eng_stat[11:8];
  assign busy   = (cstate > 4'd3);

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    tmo_n   = tmo_q;
    eidx_n  = eidx_q;
    nerr_n  = nerr_q;
    app_n   = app_q;
    er_n    = er_q;
    uc_n    = uc_q;
    to_n    = to_q;
    code_en = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (rd_start) begin
        code_en = 1'b1;
        er_n = 1'b0; uc_n = 1'b0; to_n = 1'b0; app_n = '0;
        st_n = SQ_CHECK;
      end
      SQ_CHECK: if (erased) begin
        er_n = 1'b1;
        st_n = SQ_DONE;
      end else begin
        cnt_n = CNT_W'(NWORDS - 1);
        st_n  = SQ_LOAD;
      end
      SQ_LOAD: if (cnt_q == '0) st_n = SQ_SETTLE;
               else cnt_n = cnt_q - 1'b1;
      SQ_SETTLE: st_n = SQ_SYN;
      SQ_SYN: if (eng_syn == '0) st_n = SQ_DONE;
              else begin
                tmo_n = '0;
                st_n  = SQ_WAIT_GO;
              end
      SQ_WAIT_GO: if (busy) begin
        tmo_n = '0;
        st_n  = SQ_WAIT_END;
      end else if (tmo_q == TMO_W'(TMO_CYCLES - 1)) begin
        to_n = 1'b1;
        st_n = SQ_DONE;
      end else tmo_n = tmo_q + 1'b1;
      SQ_WAIT_END: if (!busy) begin
        if (cstate == 4'd0) st_n = SQ_DONE;
        else if (cstate == 4'd1) begin
          uc_n = 1'b1;
          st_n = SQ_DONE;
        end else begin
          nerr_n = eng_stat[17:16];
          eidx_n = '0;
          st_n   = SQ_FIX;
        end
      end else if (tmo_q == TMO_W'(TMO_CYCLES - 1)) begin
        to_n = 1'b1;
        st_n = SQ_DONE;
      end else tmo_n = tmo_q + 1'b1;
      SQ_FIX: begin
        if (cur_hit) app_n = app_q + 1'b1;
        if (eidx_q == nerr_q) st_n = SQ_DONE;
        else eidx_n = eidx_q + 1'b1;
      end
      SQ_DONE: st_n = SQ_IDLE;
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      code_q <= '0;
      cnt_q  <= '0;
      tmo_q  <= '0;
      eidx_q <= '0;
      nerr_q <= '0;
      app_q  <= '0;
      er_q   <= 1'b0;
      uc_q   <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      if (code_en) code_q <= rd_code;
      cnt_q  <= cnt_n;
      tmo_q  <= tmo_n;
      eidx_q <= eidx_n;
      nerr_q <= nerr_n;
      app_q  <= app_n;
      er_q   <= er_n;
      uc_q   <= uc_n;
      to_q   <= to_n;
    end
  end

  assign ld_valid     = (st_q == SQ_LOAD);
  assign ld_word      = words[int'(cnt_q)*WORD_W +: WORD_W];
  assign calc_start   = (st_q == SQ_SYN) && (eng_syn != '0);
  assign fix_valid    = (st_q == SQ_FIX) && cur_hit;
  assign fix_idx      = cur_idx;
  assign fix_mask     = eidx_q[0] ? vreg[HALF_OFS +: 8] : vreg[7:0];
  assign done         = (st_q == SQ_DONE);
  assign done_erased  = done & er_q;
  assign done_uncorr  = done & uc_q;
  assign done_timeout = done & to_q;
  assign done_count   = done ? app_q : 3'd0;

  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_valid, calc_start, fix_valid, done}));

  assert_calc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    calc_start |=> !calc_start);

  assert_load_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_valid) |=> ld_valid);

  assert_erased_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_erased) |-> (done_count == 3'd0 && !done_timeout && !done_uncorr));

  assert_wait_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q < TMO_W'(TMO_CYCLES));

  assert_fix_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_count <= 3'd4);
endmodule

// File: tb/test_bch4_fix_unit.sv
module test_bch4_fix_unit;
  logic          clk = 1'b0;
  logic          rst_n;
  logic [127:0]  wr_par;
  logic [79:0]   wr_code;
  logic          rd_start;
  logic [79:0]   rd_code;
  logic          ld_valid;
  logic [9:0]    ld_word;
  logic [39:0]   eng_syn;
  logic          calc_start;
  logic [31:0]   eng_stat;
  logic [63:0]   err_addr, err_val;
  logic          fix_valid;
  logic [8:0]    fix_idx;
  logic [7:0]    fix_mask;
  logic          done, done_erased, done_uncorr, done_timeout;
  logic [2:0]    done_count;

  int total = 0;
  int fails = 0;
  int done_seen = 0;
  int calc_seen = 0;

  logic [9:0]  ld_q[$];
  logic [16:0] fix_q[$];
  logic [6:0]  done_q[$];

  logic [31:0] stub_final;
  logic        stub_hang;
  int          stub_cnt;
  int          stub_ph;

  always #10 clk = ~clk;

  bch4_fix_unit i_bch4_fix_unit (
    .clk(clk), .rst_n(rst_n), .wr_par(wr_par), .wr_code(wr_code),
    .rd_start(rd_start), .rd_code(rd_code), .ld_valid(ld_valid), .ld_word(ld_word),
    .eng_syn(eng_syn), .calc_start(calc_start), .eng_stat(eng_stat),
    .err_addr(err_addr), .err_val(err_val), .fix_valid(fix_valid),
    .fix_idx(fix_idx), .fix_mask(fix_mask), .done(done), .done_erased(done_erased),
    .done_uncorr(done_uncorr), .done_timeout(done_timeout), .done_count(done_count)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // Engine stub: after calc_start goes busy, then settles on stub_final.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_stat <= 32'h0; stub_cnt <= 0; stub_ph <= 0;
    end else if (calc_start) begin
      eng_stat <= 32'h0; stub_cnt <= 3; stub_ph <= 1;
    end else if (stub_ph != 0 && !stub_hang) begin
      if (stub_cnt == 0) begin
        if (stub_ph == 1) begin
          eng_stat <= 32'h0000_0F00; stub_cnt <= 4; stub_ph <= 2;
        end else begin
          eng_stat <= stub_final; stub_ph <= 0;
        end
      end else stub_cnt <= stub_cnt - 1;
    end
  end

  // Monitor: pops expected items as the design produces them.
  always @(negedge clk) begin
    if (rst_n) begin
      if (ld_valid) begin
        if (ld_q.size() == 0) check(0, "R4 unexpected load", ld_word, 0);
        else begin
          logic [9:0] e;
          e = ld_q.pop_front();
          check(ld_word == e, "R4 load word", ld_word, e);
        end
      end
      if (fix_valid) begin
        if (fix_q.size() == 0) check(0, "R9 unexpected fix", {fix_idx, fix_mask}, 0);
        else begin
          logic [16:0] e;
          e = fix_q.pop_front();
          check({fix_idx, fix_mask} == e, "R8/R9 fix", {fix_idx, fix_mask}, e);
        end
      end
      if (calc_start) calc_seen++;
      if (done) begin
        logic [6:0] a;
        a = {done_erased, done_uncorr, done_timeout, done_count, calc_seen != 0};
        if (done_q.size() == 0) check(0, "R11 extra done", a, 0);
        else begin
          logic [6:0] e;
          e = done_q.pop_front();
          check(a == e, "R3/R5/R7/R10 done record", a, e);
        end
        calc_seen = 0;
        done_seen++;
      end
    end
  end

  // Driver: computes expectations, then runs one pass.
  task automatic run_read(input logic [79:0] code, input logic [39:0] syn,
                          input logic [31:0] fstat, input logic [63:0] ea,
                          input logic [63:0] ev, input bit hang, input bit poke);
    int d0;
    int n;
    if (&code) done_q.push_back({1'b1, 1'b0, 1'b0, 3'd0, 1'b0});
    else begin
      for (int k = 7; k >= 0; k--) ld_q.push_back(code[10*k +: 10]);
      if (syn == 0) done_q.push_back(7'b0);
      else if (hang) done_q.push_back({1'b0, 1'b0, 1'b1, 3'd0, 1'b1});
      else if (fstat[11:8] == 4'd0) done_q.push_back({6'b0, 1'b1});
      else if (fstat[11:8] == 4'd1) done_q.push_back({1'b0, 1'b1, 1'b0, 3'd0, 1'b1});
      else begin
        n = 0;
        for (int i = 0; i <= int'(fstat[17:16]); i++) begin
          int a;
          logic [7:0] v;
          a = int'(ea[32*(i/2) + 16*(i%2) +: 10]);
          v = ev[32*(i/2) + 16*(i%2) +: 8];
          if (a >= 8 && a <= 519) begin
            fix_q.push_back({9'(519 - a), v});
            n++;
          end
        end
        done_q.push_back({3'b000, 3'(n), 1'b1});
      end
    end
    @(negedge clk);
    rd_code = code; eng_syn = syn; stub_final = fstat; stub_hang = hang;
    err_addr = ea; err_val = ev;
    d0 = done_seen;
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    if (poke) begin
      @(negedge clk); rd_start = 1'b1; rd_code = ~code;
      @(negedge clk); rd_start = 1'b0;
    end
    while (done_seen == d0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(ld_q.size() == 0 && fix_q.size() == 0 && done_q.size() == 0,
          "R11 queues drained", {ld_q.size(), fix_q.size(), done_q.size()}, 0);
  endtask

  task automatic pack_check(input logic [127:0] p);
    logic [79:0] e;
    wr_par = p;
    #1;
    for (int k = 0; k < 8; k++) e[10*k +: 10] = p[32*(k/2) + 16*(k%2) +: 10];
    check(wr_code == e, "R1/R2 packing", wr_code, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

  initial begin
    rst_n = 1'b0; rd_start = 1'b0; rd_code = '0; eng_syn = '0;
    err_addr = '0; err_val = '0; stub_final = '0; stub_hang = 1'b0; wr_par = '0;
    repeat (3) @(negedge clk);
    check({ld_valid, calc_start, fix_valid, done} == 4'b0, "R11 reset idle",
          {ld_valid, calc_start, fix_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R2: patterns including junk in the unused register bits
    pack_check({32'h0155_02AA, 32'h03FF_0000, 32'h0000_03FF, 32'h0123_0321});
    pack_check({32'hFC00_FC00, 32'hFC00_FC00, 32'hFC00_FC00, 32'hFC00_FC00});
    pack_check({32'h3A5C_96E1, 32'hF00F_0FF0, 32'h8421_1248, 32'hDEAD_BEEF});

    // R3: erased code
    run_read({80{1'b1}}, 40'h1, 32'h0000_0300, '0, '0, 0, 0);
    // R4, R5: one non-FF byte, zero syndrome
    run_read({8'hFE, {72{1'b1}}}, 40'h0, 32'h0, '0, '0, 0, 0);
    // R4, R5: distinct words
    run_read(80'h3C5A_9687_F0E1_D2C3_B4A5, 40'h0, 32'h0, '0, '0, 0, 0);
    // R6, R8, R9: four errors, two out of range (addr 3 -> 516, addr 600)
    run_read(80'h1234_5678_9ABC_DEF0_1357, 40'h5, 32'h0003_0300,
             {16'h0003, 16'h0258, 16'h0207, 16'h0008},
             {16'h0011, 16'h0022, 16'h0080, 16'h0001}, 0, 0);
    // R8, R9: state 2, one error at upper mirror end (addr 8 -> 511)
    run_read(80'h0102_0304_0506_0708_090A, 40'h100, 32'h0000_0200,
             {32'h0, 16'h0, 16'h0008}, {32'h0, 16'h0, 16'h00C3}, 0, 0);
    // R8: three errors, third in second register lower half
    run_read(80'hAAAA_5555_AAAA_5555_AAAA, 40'h2, 32'h0002_0300,
             {16'h0, 16'h0100, 16'h0010, 16'h0020},
             {16'h0, 16'h0044, 16'h0033, 16'h0055}, 0, 0);
    // R7: too many errors
    run_read(80'h1, 40'h7, 32'h0003_0100, {64{1'b0}}, {64{1'b1}}, 0, 0);
    // R7: state 0 after calculation
    run_read(80'h2, 40'h7, 32'h0001_0000, {16'h0, 16'h0010, 16'h0, 16'h0010},
             {64{1'b1}}, 0, 0);
    // R11: second start during a pass ignored
    run_read(80'h77, 40'h0, 32'h0, '0, '0, 0, 1);
    // R10: engine never goes busy
    run_read(80'h99, 40'h9, 32'h0, '0, '0, 1, 0);
    stub_hang = 1'b0;
    // R5 after timeout recovery
    run_read(80'h4242, 40'h0, 32'h0, '0, '0, 0, 0);

    report();
  end
endmodule